// File: doc/BRIEF.md
# Mailbox Interrupt Status Aggregator

This block merges the interrupt sources of a peripheral function that owns four outbound byte mailboxes into one interrupt line. Each mailbox reports whether it is empty and how many bytes it holds. Three auxiliary sources (counter, CPU and error) each keep an eight-bit sticky status register with a matching enable register. The block forms an eight-bit function status byte from these sources. It then folds that byte, masked by a function enable, into one bit of a top-level status register. A top-level enable register, whose bit 0 also acts as a master switch, gates that register onto the interrupt output.

Software reaches the block through a byte-wide register port with separate read and write strobes. Read data is registered and appears on the clock edge that follows the read strobe. The port also offers a per-mailbox threshold summary, a constant identification register, and an address whose access (read or write) clears the counter status. Mailbox storage, command handling and the transport that carries register accesses all sit outside the block.

Top module: `mbox_irq_agg`

## Requirements
- R1: Function status bits 3..0 are 1 exactly when the matching bit of `mbox_empty` is 0, in the same cycle.
- R2: Function status bit 4 is the OR of (counter status AND counter enable). Bit 6 is the OR of (CPU status AND CPU enable), and bit 7 is the OR of (error status AND error enable). Bit 5 is always 0.
- R3: Top-level status (offset 0x005) has bit 1 equal to the OR of (function status AND function enable). All of its other bits are 0.
- R4: `irq` is registered. It is 1 one clock after a cycle in which top enable bit 0 is 1 and (top status AND top enable) is nonzero, and 0 otherwise.
- R5: Reads return data on the clock edge after `reg_rd`. Enables are read/write: function 0x418, CPU 0x419, error 0x41A, counter 0x41B, top 0x004. Statuses are read-only: function 0x400, CPU 0x401, error 0x402, counter 0x403; writes to them have no effect. Unmapped offsets read 0.
- R6: Offset 0x405 returns bit i = 1 when mailbox i level is at least THRESH (default 4). Bits 7..4 are 0.
- R7: A read or a write at offset 0x440 clears all counter status bits, and a read there returns 0. A counter set input that arrives in the same cycle takes priority over the clear.
- R8: Offset 0x450 always reads 0x01.
- R9: Each auxiliary status register is sticky: a 1 on a bit of its set input makes that bit 1 on the next clock, and other bits keep their value.
- R10: A synchronous reset clears all enable registers, all auxiliary status registers, `irq` and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| mbox_empty | input | 4 | Per-mailbox empty flags |
| mbox_level | input | 4*LVL_W | Per-mailbox byte counts, mailbox 0 in the low field |
| cnt_set | input | 8 | Counter status set pulses |
| cpu_set | input | 8 | CPU status set pulses |
| err_set | input | 8 | Error status set pulses |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with LVL_W = 10 and THRESH = 4. With these values it can place mailbox levels of 3 and 4 on either side of the threshold, and it can also drive the full 0x3FF count. The bench walks each auxiliary source from masked to unmasked. It checks the master bit and the top-level mask separately, so that each one alone holds the line low. It also checks that a counter set arriving in the same cycle as a clear access takes priority.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    localparam int AW = 12;

    localparam logic [AW-1:0] OFS_TOP_EN   = 12'h004;
    localparam logic [AW-1:0] OFS_TOP_STAT = 12'h005;
    localparam logic [AW-1:0] OFS_FN_STAT  = 12'h400;
    localparam logic [AW-1:0] OFS_CPU_STAT = 12'h401;
    localparam logic [AW-1:0] OFS_ERR_STAT = 12'h402;
    localparam logic [AW-1:0] OFS_CNT_STAT = 12'h403;
    localparam logic [AW-1:0] OFS_THRESH   = 12'h405;
    localparam logic [AW-1:0] OFS_FN_EN    = 12'h418;
    localparam logic [AW-1:0] OFS_CPU_EN   = 12'h419;
    localparam logic [AW-1:0] OFS_ERR_EN   = 12'h41A;
    localparam logic [AW-1:0] OFS_CNT_EN   = 12'h41B;
    localparam logic [AW-1:0] OFS_CNT_CLR  = 12'h440;
    localparam logic [AW-1:0] OFS_IDENT    = 12'h450;

    localparam logic [7:0] IDENT_VAL = 8'h01;

    // Index of each auxiliary source in the sticky status array
    localparam int SRC_CNT = 0;
    localparam int SRC_CPU = 1;
    localparam int SRC_ERR = 2;
    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic [7:0] fn_en;
        logic [7:0] cpu_en;
        logic [7:0] err_en;
        logic [7:0] cnt_en;
        logic [7:0] top_en;
        logic       irq;
        logic [7:0] rdata;
    } agg_regs_t;

endpackage

// File: rtl/aux_stat_reg.sv
module aux_stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q;

    // Set takes priority over a clear in the same cycle
    always_comb begin
        stat_d = (clr_i ? '0 : stat_q) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/mbox_flag_gen.sv
module mbox_flag_gen #(
    parameter int N      = 4,
    parameter int LVL_W  = 10,
    parameter int THRESH = 4
) (
    input  logic [N-1:0]       empty_i,
    input  logic [N*LVL_W-1:0] level_i,
    output logic [N-1:0]       nonempty_o,
    output logic [N-1:0]       above_o
);
    localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);

    for (genvar i = 0; i < N; i++) begin : g_mbox
        assign nonempty_o[i] = ~empty_i[i];
        assign above_o[i]    = (level_i[i*LVL_W +: LVL_W] >= THR);
    end
endmodule

// File: rtl/mbox_irq_agg.sv
module mbox_irq_agg
    import mbox_irq_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int THRESH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [3:0]         mbox_empty,
    input  logic [4*LVL_W-1:0] mbox_level,
    input  logic [7:0]         cnt_set,
    input  logic [7:0]         cpu_set,
    input  logic [7:0]         err_set,
    output logic               irq
);
    localparam int NMB = 4;

    agg_regs_t r_d, r_q;

    logic [NMB-1:0]          nonempty, above;
    logic [NUM_SRC-1:0][7:0] set_v, stat_v;
    logic [NUM_SRC-1:0]      clr_v;
    logic [7:0]              cnt_stat, cpu_stat, err_stat;
    logic [7:0]              fn_stat, top_stat;
    logic                    cnt_clr;

    mbox_flag_gen #(.N(NMB), .LVL_W(LVL_W), .THRESH(THRESH)) u_flags (
        .empty_i    (mbox_empty),
        .level_i    (mbox_level),
        .nonempty_o (nonempty),
        .above_o    (above)
    );

    assign cnt_clr = (reg_rd || reg_wr) && (reg_addr == OFS_CNT_CLR);

    assign set_v[SRC_CNT] = cnt_set;
    assign set_v[SRC_CPU] = cpu_set;
    assign set_v[SRC_ERR] = err_set;
    assign clr_v = NUM_SRC'(1) << SRC_CNT;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        aux_stat_reg #(.W(8)) u_stat (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[s]),
            .clr_i  (clr_v[s] & cnt_clr),
            .stat_o (stat_v[s])
        );
    end

    assign cnt_stat = stat_v[SRC_CNT];
    assign cpu_stat = stat_v[SRC_CPU];
    assign err_stat = stat_v[SRC_ERR];

    always_comb begin
        fn_stat  = {|(err_stat & r_q.err_en),
                    |(cpu_stat & r_q.cpu_en),
                    1'b0,
                    |(cnt_stat & r_q.cnt_en),
                    nonempty};
        top_stat = {6'b0, |(fn_stat & r_q.fn_en), 1'b0};

        r_d     = r_q;
        r_d.irq = r_q.top_en[0] && |(top_stat & r_q.top_en);

        if (reg_wr) begin
            unique case (reg_addr)
                OFS_TOP_EN: r_d.top_en = reg_wdata;
                OFS_FN_EN:  r_d.fn_en  = reg_wdata;
                OFS_CPU_EN: r_d.cpu_en = reg_wdata;
                OFS_ERR_EN: r_d.err_en = reg_wdata;
                OFS_CNT_EN: r_d.cnt_en = reg_wdata;
                default: ;
            endcase
        end

        if (reg_rd) begin
            unique case (reg_addr)
                OFS_TOP_EN:   r_d.rdata = r_q.top_en;
                OFS_TOP_STAT: r_d.rdata = top_stat;
                OFS_FN_STAT:  r_d.rdata = fn_stat;
                OFS_CPU_STAT: r_d.rdata = cpu_stat;
                OFS_ERR_STAT: r_d.rdata = err_stat;
                OFS_CNT_STAT: r_d.rdata = cnt_stat;
                OFS_THRESH:   r_d.rdata = {4'b0, above};
                OFS_FN_EN:    r_d.rdata = r_q.fn_en;
                OFS_CPU_EN:   r_d.rdata = r_q.cpu_en;
                OFS_ERR_EN:   r_d.rdata = r_q.err_en;
                OFS_CNT_EN:   r_d.rdata = r_q.cnt_en;
                OFS_IDENT:    r_d.rdata = IDENT_VAL;
                default:      r_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;
    assign irq       = r_q.irq;
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] reg_addr,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic [7:0]  reg_rdata,
    input logic [3:0]  mbox_empty,
    input logic [7:0]  cnt_set,
    input logic        irq,
    input logic [7:0]  top_en,
    input logic [7:0]  fn_en,
    input logic [7:0]  cnt_stat
);
    AST_MASTER_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        !top_en[0] |=> !irq); // R4

    AST_MBOX_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (top_en[0] && top_en[1] && |(~mbox_empty & fn_en[3:0])) |=> irq); // R1

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 12'h450) |=> (reg_rdata == 8'h01)); // R8

    AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 12'h440) |=> (reg_rdata == 8'h00)); // R7

    AST_CLR_EMPTIES_CNT: assert property (@(posedge clk) disable iff (rst)
        ((reg_rd || reg_wr) && reg_addr == 12'h440 && cnt_set == 8'h00)
        |=> (cnt_stat == 8'h00)); // R7

    AST_CNT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cnt_set != 8'h00) |=> ((cnt_stat & $past(cnt_set)) == $past(cnt_set))); // R9
endmodule

bind mbox_irq_agg mbox_irq_chk u_mbox_irq_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .mbox_empty (mbox_empty),
    .cnt_set    (cnt_set),
    .irq        (irq),
    .top_en     (r_q.top_en),
    .fn_en      (r_q.fn_en),
    .cnt_stat   (cnt_stat)
);

// File: tb/test_mbox_irq_agg.sv
module test_mbox_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic [11:0]        reg_addr;
    logic               reg_rd, reg_wr;
    logic [7:0]         reg_wdata, reg_rdata;
    logic [3:0]         mbox_empty;
    logic [4*LVL_W-1:0] mbox_level;
    logic [7:0]         cnt_set, cpu_set, err_set;
    logic               irq;

    mbox_irq_agg #(.LVL_W(LVL_W), .THRESH(4)) i_mbox_irq_agg (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mbox_empty(mbox_empty), .mbox_level(mbox_level),
        .cnt_set(cnt_set), .cpu_set(cpu_set), .err_set(err_set), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [11:0] addr;
        logic [7:0]  exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb[$];
    rd_item_t mon_it;
    int       n_vec = 0;
    int       n_bad = 0;
    logic     mon_pend = 1'b0;
    bit       done = 1'b0;

    // Monitor: a read strobe seen at an edge yields data checked at the next falling edge
    always @(posedge clk) mon_pend <= reg_rd;

    always @(negedge clk) begin
        if (mon_pend) begin
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read data %02h, expected none", reg_rdata);
            end else begin
                mon_it = sb.pop_front();
                if (reg_rdata !== mon_it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %03h got %02h expected %02h",
                             mon_it.tag, mon_it.addr, reg_rdata, mon_it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        sb.push_back('{a, e, tag});
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_vec++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic set_empty(input logic [3:0] v);
        @(negedge clk);
        mbox_empty = v;
    endtask

    task automatic pulse(input int which, input logic [7:0] v);
        @(negedge clk);
        case (which)
            0: cnt_set = v;
            1: cpu_set = v;
            default: err_set = v;
        endcase
        @(negedge clk);
        cnt_set = '0; cpu_set = '0; err_set = '0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        mbox_empty = 4'hF; mbox_level = '0; cnt_set = '0; cpu_set = '0; err_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state, R8 identification, R5 unmapped
        chk_irq(1'b0, "R10");
        rd(12'h418, 8'h00, "R10 fn enable");
        rd(12'h401, 8'h00, "R10 cpu status");
        rd(12'h400, 8'h00, "R1 all empty");
        rd(12'h450, 8'h01, "R8");
        rd(12'h123, 8'h00, "R5 unmapped");

        // R1 mailbox 2 not empty
        set_empty(4'b1011);
        rd(12'h400, 8'h04, "R1");
        rd(12'h005, 8'h00, "R3 fn enable off");

        // R3 / R4 top-level status and gating
        wr(12'h418, 8'h04);
        rd(12'h418, 8'h04, "R5 fn enable");
        rd(12'h005, 8'h02, "R3");
        chk_irq(1'b0, "R4 top enable zero");
        wr(12'h004, 8'h02);
        chk_irq(1'b0, "R4 master bit off");
        wr(12'h004, 8'h01);
        chk_irq(1'b0, "R4 status bit masked");
        wr(12'h004, 8'h03);
        chk_irq(1'b1, "R4 enabled");
        rd(12'h004, 8'h03, "R5 top enable");
        set_empty(4'hF);
        chk_irq(1'b0, "R1 mailbox drained");
        set_empty(4'b1011);
        chk_irq(1'b1, "R1 mailbox refilled");

        // R2 / R9 auxiliary sources
        pulse(1, 8'h20);
        rd(12'h401, 8'h20, "R9 cpu set");
        rd(12'h400, 8'h04, "R2 cpu masked");
        wr(12'h419, 8'h20);
        rd(12'h400, 8'h44, "R2 cpu enabled");
        pulse(1, 8'h01);
        rd(12'h401, 8'h21, "R9 sticky");
        pulse(2, 8'h80);
        wr(12'h41A, 8'h80);
        rd(12'h400, 8'hC4, "R2 error enabled");
        pulse(0, 8'h03);
        wr(12'h41B, 8'h02);
        rd(12'h400, 8'hD4, "R2 counter enabled");
        rd(12'h403, 8'h03, "R9 counter status");

        // R7 counter clear by read, by write, and set priority
        rd(12'h440, 8'h00, "R7 read returns zero");
        rd(12'h403, 8'h00, "R7 cleared by read");
        rd(12'h400, 8'hC4, "R7 function bit 4 drops");
        pulse(0, 8'h04);
        wr(12'h440, 8'h55);
        rd(12'h403, 8'h00, "R7 cleared by write");
        @(negedge clk);
        cnt_set = 8'h08; reg_addr = 12'h440; reg_wr = 1'b1;
        @(negedge clk);
        cnt_set = 8'h00; reg_wr = 1'b0;
        rd(12'h403, 8'h08, "R7 set wins over clear");

        // R5 status registers are read-only
        wr(12'h401, 8'h00);
        rd(12'h401, 8'h21, "R5 status write ignored");

        // R6 threshold readout
        @(negedge clk);
        mbox_level = {10'd0, 10'd9, 10'd4, 10'd3};
        rd(12'h405, 8'h06, "R6 straddle");
        @(negedge clk);
        mbox_level = {4{10'h3FF}};
        rd(12'h405, 8'h0F, "R6 full count");

        // R3 error source alone drives the top bit
        wr(12'h418, 8'h80);
        chk_irq(1'b1, "R3 via error bit");
        wr(12'h418, 8'h00);
        chk_irq(1'b0, "R3 all masked");

        // R10 reset clears enables and status
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(12'h419, 8'h00, "R10 cpu enable");
        rd(12'h401, 8'h00, "R10 cpu status");
        chk_irq(1'b0, "R10 irq");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL scoreboard: %0d reads pending, expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule